// File: doc/BRIEF.md
# Dual-Mode Port with Chip-Select Strobes

This block is an eight-bit port that runs in one of two modes. In general-purpose mode it has a data register and a direction register that software reads and writes through a small register interface. A port-wide pull-up enable applies a pull-up to any pin that is an input. In emulation mode, selected by a mode bit, the same eight pins carry the expansion page and two active-low chip-select strobes. Bits 5:0 carry page address bits 19 down to 14 of a 20-bit expanded address. Bit 6 is the chip select for ordinary external accesses. Bit 7 is the chip select for accesses that emulate internal memory expansion.

The block runs on a clock four times the external bus clock. A 2-bit phase counter is reloaded by a pulse marking each bus-clock falling edge. Each strobe is forced to its released (high) level for the one fast-clock phase that follows that edge. The release is skipped when the access is stretched and the bus clock is free-running. When emulation mode is on and the part runs in an expanded or peripheral operating mode, the data register leaves the local map. Accesses to it are then flagged for forwarding to the external bus, and the local copy is left unchanged.

Top module: `xport_top`

## Requirements
- R1: In general-purpose mode, a pin whose direction bit is 1 has its output enable set and drives the stored data bit.
- R2: In general-purpose mode, a pin whose direction bit is 0 has its output enable clear.
- R3: A read at address 1 returns the direction register. A read at address 0 returns, bit by bit, the stored data bit where the direction bit is 1 and the pin input level where it is 0.
- R4: In general-purpose mode, the pull-up output of a pin is set exactly when the pull-up enable input is 1 and that pin's direction bit is 0.
- R5: In emulation mode, all eight output enables are 1, all pull-ups are 0, and pin outputs 5:0 equal the page input.
- R6: In emulation mode, outside a release phase, pin output 7 is the inverse of the internal-expansion select and pin output 6 is the inverse of the external select.
- R7: The phase counter loads 0 on the edge that samples a falling-edge pulse and otherwise counts up modulo 4. In emulation mode, pin outputs 7 and 6 are both 1 while the phase is 0.
- R8: When both stretch and free-run are 1, the phase-0 release does not happen and the strobes follow R6 in every phase.
- R9: With emulation mode and expanded operation both set, an access at address 0 raises the forward flag, reads 0, and a write there leaves the data register unchanged. The direction register stays local.
- R10: After reset the data and direction registers are 0, and emulation mode is off only when its input is 0 (the mode is an input, not stored state).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock, four times the bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | 1 | 0 selects data, 1 selects direction |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data |
| fwd_o | output | 1 | Access forwarded to the external bus |
| emu_en_i | input | 1 | Emulation mode enable |
| exp_mode_i | input | 1 | Expanded or peripheral operation |
| stretch_i | input | 1 | Current external access is stretched |
| freerun_i | input | 1 | Bus clock is free-running |
| pull_en_i | input | 1 | Port-wide pull-up enable |
| eclk_fall_i | input | 1 | Pulse marking a bus-clock falling edge |
| emu_sel_i | input | 1 | Internal-expansion access selected |
| ext_sel_i | input | 1 | Other external access selected |
| page_i | input | 6 | Page address bits 19:14 |
| pin_i | input | 8 | Buffered pin levels |
| pin_o | output | 8 | Pin output data |
| pin_oe_o | output | 8 | Pin output enables |
| pin_pu_o | output | 8 | Pin pull-up enables |

## Verification
General-purpose mode is swept over sixteen direction patterns, each against several data and pin-level patterns. This separates bits that come from the register from bits that come from the pin, both in the read path and in the output enables and pull-ups. Emulation mode is swept over every page value, every combination of the two selects and all four stretch/free-run settings, across all four phases. This shows whether the release sits in the right phase and whether it is suppressed only when both stretch and free-run are set. The forwarding case writes a distinct value and then reads the register back in general-purpose mode, which shows that the forwarded write did not reach the local register.

// File: rtl/xport_pkg.sv
package xport_pkg;
    localparam int unsigned PORT_W  = 8;
    localparam int unsigned PHASE_W = 2;

    typedef enum logic {
        XP_ADDR_DATA = 1'b0,
        XP_ADDR_DIR  = 1'b1
    } xp_addr_e;
endpackage

// File: rtl/xport_regs.sv
module xport_regs
    import xport_pkg::*;
#(
    parameter int unsigned W = PORT_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_i,
    input  logic         rd_i,
    input  logic         addr_i,
    input  logic [W-1:0] wdata_i,
    input  logic [W-1:0] pin_i,
    input  logic         emu_en_i,
    input  logic         exp_mode_i,
    output logic [W-1:0] rdata_o,
    output logic         fwd_o,
    output logic [W-1:0] data_o,
    output logic [W-1:0] dir_o
);
    typedef struct packed {
        logic [W-1:0] data;
        logic [W-1:0] dir;
    } regs_t;

    regs_t st_d, st_q;
    logic  data_hit;
    logic  unmapped;

    always_comb begin
        data_hit = (addr_i == XP_ADDR_DATA);
        unmapped = emu_en_i && exp_mode_i;
        fwd_o    = (wr_i || rd_i) && data_hit && unmapped;

        st_d = st_q;
        if (wr_i) begin
            if (!data_hit) begin
                st_d.dir = wdata_i;
            end else if (!unmapped) begin
                st_d.data = wdata_i;
            end
        end

        if (!data_hit) begin
            rdata_o = st_q.dir;
        end else if (unmapped) begin
            rdata_o = '0;
        end else begin
            rdata_o = (st_q.dir & st_q.data) | (~st_q.dir & pin_i);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign data_o = st_q.data;
    assign dir_o  = st_q.dir;

    // R9: a forwarded write must not reach the local data register
    a_r9_fwd_keeps_data: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && fwd_o) |=> $stable(st_q.data));
endmodule

// File: rtl/xport_phase.sv
module xport_phase
    import xport_pkg::*;
#(
    parameter int unsigned PW = PHASE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fall_i,
    output logic [PW-1:0] phase_o,
    output logic          rel_o
);
    typedef struct packed {
        logic [PW-1:0] phase;
    } ph_t;

    ph_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (fall_i) begin
            st_d.phase = '0;
        end else begin
            st_d.phase = st_q.phase + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign phase_o = st_q.phase;
    assign rel_o   = (st_q.phase == '0);

    // R7: a falling-edge pulse restarts the phase count
    a_r7_phase_load: assert property (@(posedge clk) disable iff (!rst_n)
        fall_i |=> (phase_o == '0));
    // R7: between pulses the phase advances modulo four
    a_r7_phase_step: assert property (@(posedge clk) disable iff (!rst_n)
        !fall_i |=> (phase_o == PW'($past(phase_o) + 1'b1)));
endmodule

// File: rtl/xport_pinmux.sv
module xport_pinmux
    import xport_pkg::*;
#(
    parameter int unsigned W = PORT_W,
    localparam int unsigned PG_W = W - 2
) (
    input  logic            emu_en_i,
    input  logic            pull_en_i,
    input  logic            stretch_i,
    input  logic            freerun_i,
    input  logic            rel_i,
    input  logic            emu_sel_i,
    input  logic            ext_sel_i,
    input  logic [PG_W-1:0] page_i,
    input  logic [W-1:0]    data_i,
    input  logic [W-1:0]    dir_i,
    output logic [W-1:0]    pin_o,
    output logic [W-1:0]    oe_o,
    output logic [W-1:0]    pu_o
);
    logic hold_off;

    always_comb begin
        hold_off = rel_i && !(stretch_i && freerun_i);
        if (emu_en_i) begin
            pin_o[W-1]    = hold_off | ~emu_sel_i;
            pin_o[W-2]    = hold_off | ~ext_sel_i;
            pin_o[PG_W-1:0] = page_i;
            oe_o          = '1;
            pu_o          = '0;
        end else begin
            pin_o = data_i;
            oe_o  = dir_i;
            pu_o  = ~dir_i & {W{pull_en_i}};
        end
    end
endmodule

// File: rtl/xport_top.sv
module xport_top
    import xport_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  reg_wr_i,
    input  logic                  reg_rd_i,
    input  logic                  reg_addr_i,
    input  logic [PORT_W-1:0]     reg_wdata_i,
    output logic [PORT_W-1:0]     reg_rdata_o,
    output logic                  fwd_o,
    input  logic                  emu_en_i,
    input  logic                  exp_mode_i,
    input  logic                  stretch_i,
    input  logic                  freerun_i,
    input  logic                  pull_en_i,
    input  logic                  eclk_fall_i,
    input  logic                  emu_sel_i,
    input  logic                  ext_sel_i,
    input  logic [PORT_W-3:0]     page_i,
    input  logic [PORT_W-1:0]     pin_i,
    output logic [PORT_W-1:0]     pin_o,
    output logic [PORT_W-1:0]     pin_oe_o,
    output logic [PORT_W-1:0]     pin_pu_o
);
    logic [PORT_W-1:0]  data_w, dir_w;
    logic [PHASE_W-1:0] phase_w;
    logic               rel_w;

    xport_regs #(.W(PORT_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_i(reg_wr_i), .rd_i(reg_rd_i), .addr_i(reg_addr_i),
        .wdata_i(reg_wdata_i), .pin_i(pin_i),
        .emu_en_i(emu_en_i), .exp_mode_i(exp_mode_i),
        .rdata_o(reg_rdata_o), .fwd_o(fwd_o),
        .data_o(data_w), .dir_o(dir_w)
    );

    xport_phase #(.PW(PHASE_W)) u_phase (
        .clk(clk), .rst_n(rst_n), .fall_i(eclk_fall_i),
        .phase_o(phase_w), .rel_o(rel_w)
    );

    xport_pinmux #(.W(PORT_W)) u_mux (
        .emu_en_i(emu_en_i), .pull_en_i(pull_en_i),
        .stretch_i(stretch_i), .freerun_i(freerun_i),
        .rel_i(rel_w), .emu_sel_i(emu_sel_i), .ext_sel_i(ext_sel_i),
        .page_i(page_i), .data_i(data_w), .dir_i(dir_w),
        .pin_o(pin_o), .oe_o(pin_oe_o), .pu_o(pin_pu_o)
    );

    // R7: both strobes released in phase 0 unless stretched with free-running clock
    a_r7_release: assert property (@(posedge clk) disable iff (!rst_n)
        (emu_en_i && phase_w == '0 && !(stretch_i && freerun_i))
            |-> (pin_o[PORT_W-1:PORT_W-2] == 2'b11));
    // R5: emulation mode enables every driver
    a_r5_emu_drive: assert property (@(posedge clk) disable iff (!rst_n)
        emu_en_i |-> (pin_oe_o == '1 && pin_pu_o == '0));
    // R1/R2: general-purpose enables follow the stored direction
    a_r1_gpio_oe: assert property (@(posedge clk) disable iff (!rst_n)
        !emu_en_i |-> (pin_oe_o == dir_w));
endmodule

// File: tb/xport_top_tb.sv
module xport_top_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 0, reg_rd = 0, reg_addr = 0;
    logic [7:0] reg_wdata = 0, reg_rdata;
    logic       fwd;
    logic       emu_en = 0, exp_mode = 0, stretch = 0, freerun = 0, pull_en = 0;
    logic       eclk_fall = 0, emu_sel = 0, ext_sel = 0;
    logic [5:0] page = 0;
    logic [7:0] pin_in = 0, pin_out, pin_oe, pin_pu;

    int n_tests = 0;
    int n_fail  = 0;

    always #10 clk = ~clk;

    xport_top u_dut (
        .clk(clk), .rst_n(rst_n),
        .reg_wr_i(reg_wr), .reg_rd_i(reg_rd), .reg_addr_i(reg_addr),
        .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .fwd_o(fwd),
        .emu_en_i(emu_en), .exp_mode_i(exp_mode),
        .stretch_i(stretch), .freerun_i(freerun), .pull_en_i(pull_en),
        .eclk_fall_i(eclk_fall), .emu_sel_i(emu_sel), .ext_sel_i(ext_sel),
        .page_i(page), .pin_i(pin_in),
        .pin_o(pin_out), .pin_oe_o(pin_oe), .pin_pu_o(pin_pu)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic a, input logic [7:0] v);
        @(negedge clk);
        reg_wr = 1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_wr = 0;
        #1;
    endtask

    task automatic rd_reg(input logic a);
        reg_rd = 1; reg_addr = a;
        #1;
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=%h expected=%h", 8'h0, 8'h1);
        finish_run();
    end

    initial begin
        logic [7:0] data_v, exp_rd;
        int ph;
        logic rel;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk); #1;

        // R10: reset clears direction and data
        rd_reg(1); chk("R10 dir reset", reg_rdata, 8'h00);
        pin_in = 8'h5A; rd_reg(0); chk("R10 read after reset", reg_rdata, 8'h5A);
        chk("R10 oe after reset", pin_oe, 8'h00);
        wr_reg(1, 8'hFF); rd_reg(0); chk("R10 data reset", reg_rdata, 8'h00);
        reg_rd = 0;

        // R1 R2 R3 R4: direction sweep in general-purpose mode
        for (int d = 0; d < 256; d += 17) begin
            for (int k = 0; k < 3; k++) begin
                data_v = 8'(d * 7 + k * 85 + 3);
                pull_en = k[0];
                wr_reg(1, 8'(d));
                wr_reg(0, data_v);
                for (int p = 0; p < 4; p++) begin
                    pin_in = 8'(p * 67 + d);
                    #1;
                    chk("R1 pin out on outputs", pin_out & 8'(d), data_v & 8'(d));
                    chk("R2 oe follows dir", pin_oe, 8'(d));
                    chk("R4 pull-up", pin_pu, pull_en ? ~8'(d) : 8'h00);
                    exp_rd = (8'(d) & data_v) | (~8'(d) & pin_in);
                    rd_reg(0); chk("R3 data read mix", reg_rdata, exp_rd);
                    rd_reg(1); chk("R3 dir read", reg_rdata, 8'(d));
                    reg_rd = 0;
                end
            end
        end

        // R5 R6 R7 R8: emulation mode sweep
        wr_reg(1, 8'h00);
        pull_en = 1; emu_en = 1;
        for (int s = 0; s < 4; s++) begin
            stretch = s[1]; freerun = s[0];
            for (int sel = 0; sel < 4; sel++) begin
                emu_sel = sel[1]; ext_sel = sel[0];
                @(negedge clk); eclk_fall = 1;
                @(negedge clk); eclk_fall = 0;
                for (ph = 0; ph < 4; ph++) begin
                    page = 6'(s * 16 + sel * 4 + ph);
                    #1;
                    rel = (ph == 0) && !(stretch && freerun);
                    if (stretch && freerun)
                        chk("R8 no release", {6'b0, pin_out[7:6]}, {6'b0, ~emu_sel, ~ext_sel});
                    else if (rel)
                        chk("R7 release phase", {6'b0, pin_out[7:6]}, 8'h03);
                    else
                        chk("R6 strobes", {6'b0, pin_out[7:6]}, {6'b0, ~emu_sel, ~ext_sel});
                    chk("R5 page", {2'b0, pin_out[5:0]}, {2'b0, page});
                    chk("R5 oe", pin_oe, 8'hFF);
                    chk("R5 pu", pin_pu, 8'h00);
                    @(negedge clk);
                end
            end
        end
        // R5: full page sweep
        for (int pg = 0; pg < 64; pg++) begin
            page = 6'(pg); #1;
            chk("R5 page sweep", {2'b0, pin_out[5:0]}, 8'(pg));
        end

        // R9: forwarding in expanded emulation
        emu_en = 0; wr_reg(1, 8'hFF); wr_reg(0, 8'h3C);
        emu_en = 1; exp_mode = 1;
        @(negedge clk);
        reg_wr = 1; reg_addr = 0; reg_wdata = 8'hA5; #1;
        chk("R9 forward flag", {7'b0, fwd}, 8'h01);
        chk("R9 read zero", reg_rdata, 8'h00);
        @(negedge clk); reg_wr = 0; #1;
        chk("R9 idle no forward", {7'b0, fwd}, 8'h00);
        wr_reg(1, 8'h0F);
        rd_reg(1); chk("R9 dir local", reg_rdata, 8'h0F);
        chk("R9 dir access no forward", {7'b0, fwd}, 8'h00);
        reg_rd = 0;
        emu_en = 0; exp_mode = 0; wr_reg(1, 8'hFF);
        rd_reg(0); chk("R9 data unchanged", reg_rdata, 8'h3C);
        reg_rd = 0;
        // R9: single-chip emulation keeps the register local
        emu_en = 1; wr_reg(0, 8'h77); emu_en = 0; #1;
        rd_reg(0); chk("R9 local when not expanded", reg_rdata, 8'h77);
        reg_rd = 0;

        finish_run();
    end
endmodule